// File: doc/BRIEF.md
# Ethernet Transmit Frame Builder

This block turns a stream of frame bytes into a complete serial Ethernet frame. The source hands over the header and payload one byte at a time on a valid/ready interface: six destination address bytes, six source address bytes, the two-byte length/type field with its high byte first, then the data bytes. The source marks the final byte with a last flag. The block adds the opening preamble and the start-of-frame delimiter in front. It fills a short payload with zero bytes up to the minimum frame size. It then appends a CRC-32 frame check sequence, unless the check sequence has been switched off for that frame.

The output is one bit per clock, together with a strobe that is high for every bit of the frame. The first byte the source offers while the block is idle starts a frame. The block takes no further frame until the last bit of the current one has left the serial output. Media access timing, collision handling, interframe spacing and line coding belong to neighbouring logic.

Top module: `eth_tx_framer`

## Requirements
- R1: While txActive is low (after reset and between frames), inReady is high and txBit is 0.
- R2: A frame starts with 7 bytes of 0x55 and then the delimiter byte 0xD5, each sent bit 0 first, so the line carries 1,0,1,0,... for 56 bits and then 10101011.
- R3: Every accepted byte is sent in the order it was accepted, bit 0 first and bit 7 last, straight after the delimiter; the length/type field goes out high byte first because the source supplies it in that order.
- R4: When the accepted bytes (header plus data) number fewer than 60, zero bytes follow them until 60 bytes have been sent after the delimiter.
- R5: With the check sequence enabled, 4 bytes follow the data and padding. They hold the complement of the CRC-32 (polynomial 0x04C11DB7, register preset to all ones) over every byte after the delimiter, including pad, with each byte's bits fed bit 0 first. The coefficient of x^31 is sent first and x^0 last.
- R6: fcsDisable is sampled when a frame's first byte is accepted. When it is 1, that frame ends right after its data or padding with no check sequence, and later changes of fcsDisable do not affect a frame already in progress.
- R7: After the byte flagged last has been accepted, inReady stays low until txActive falls, and bytes offered in that time do not appear in the frame.
- R8: txActive rises the cycle after the first byte is accepted and stays high for exactly the frame's bits, a multiple of 8 and at least 544. It falls after the final bit, and a new first byte is accepted in the first cycle with txActive low.
- R9: When 60 or more bytes are accepted, no pad byte is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fcsDisable | input | 1 | 1 = send the next frame without a check sequence |
| inValid | input | 1 | A byte is offered on inData |
| inData | input | 8 | Frame byte: header, then data |
| inLast | input | 1 | The offered byte is the frame's final byte |
| inReady | output | 1 | The block takes the offered byte at this clock edge |
| txBit | output | 1 | Serial frame bit |
| txActive | output | 1 | High for every bit of a frame |

## Verification
The hardest situation to reach is a frame start that arrives in the single idle cycle after the last check-sequence bit, while bytes are still being offered after the previous frame's last byte. The bench creates it by keeping inValid high with a junk byte flagged last from the moment the last byte is accepted until txActive falls. It then presents the next frame's first byte in that same idle cycle. This drives the handshake across the frame boundary in both directions. The frames cover short payloads that need 45 pad bytes or 1, exactly 60 bytes, long payloads, and the check sequence switched off on both padded and unpadded frames. The frame with the check sequence off follows straight after one with it on, so a change of the setting between frames is also exercised.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  localparam logic [7:0]  PRE_BYTE  = 8'h55;
  localparam logic [7:0]  SFD_BYTE  = 8'hD5;
  localparam logic [31:0] CRC_REFL  = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    SRC_PRE,
    SRC_SFD,
    SRC_HOLD,
    SRC_ZERO,
    SRC_FCS
  } byteSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     capture;   // take the offered input byte into the holding register
    logic     load;      // load the shifter with a new byte
    byteSrc_t src;       // which byte to load
    logic     shift;     // move the shifter on by one bit
    logic     crcInit;   // preset the CRC
    logic     crcFeed;   // fold the loaded byte into the CRC
    logic     crcDrain;  // drop the low CRC byte after it has been loaded
  } dpCtrl_t;

  // one byte of CRC-32 in the bit-reversed register form, bit 0 of data first
  function automatic logic [31:0] crcByte(input logic [31:0] crcIn, input logic [7:0] d);
    logic [31:0] c;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/eth_tx_datapath.sv
module eth_tx_datapath
  import eth_tx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [BYTE_W-1:0] inData,
  output logic              serBit
);

  localparam int CRC_W = 32;

  logic [BYTE_W-1:0] holdReg;
  logic [BYTE_W-1:0] shReg;
  logic [CRC_W-1:0]  crcReg;
  logic [BYTE_W-1:0] nextByte;
  logic [CRC_W-1:0]  fcsWord;

  assign fcsWord = ~crcReg;

  always_comb begin
    unique case (ctrl.src)
      SRC_PRE:  nextByte = PRE_BYTE;
      SRC_SFD:  nextByte = SFD_BYTE;
      SRC_HOLD: nextByte = holdReg;
      SRC_ZERO: nextByte = '0;
      SRC_FCS:  nextByte = fcsWord[BYTE_W-1:0];
      default:  nextByte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (ctrl.capture) begin
      holdReg <= inData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (ctrl.load) begin
      shReg <= nextByte;
    end else if (ctrl.shift) begin
      shReg <= {1'b0, shReg[BYTE_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= CRC_SEED;
    end else if (ctrl.crcInit) begin
      crcReg <= CRC_SEED;
    end else if (ctrl.crcFeed) begin
      crcReg <= crcByte(crcReg, nextByte);
    end else if (ctrl.crcDrain) begin
      crcReg <= {{BYTE_W{1'b1}}, crcReg[CRC_W-1:BYTE_W]};
    end
  end

  assign serBit = shReg[0];

endmodule

// File: rtl/eth_tx_control.sv
module eth_tx_control
  import eth_tx_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int HDR_BYTES = 14,
  parameter int MIN_DATA  = 46,
  parameter int FCS_BYTES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    fcsDisable,
  input  logic    inValid,
  input  logic    inLast,
  output logic    inReady,
  output logic    frameOn,
  output dpCtrl_t dp
);

  localparam int MIN_BODY = HDR_BYTES + MIN_DATA;
  localparam int CNT_W    = $clog2(MIN_BODY + 1);
  localparam int SEG_MAX  = (PRE_BYTES > FCS_BYTES) ? PRE_BYTES : FCS_BYTES;
  localparam int SEG_W    = $clog2(SEG_MAX + 1);
  localparam logic [SEG_W-1:0] LAST_PRE = SEG_W'(PRE_BYTES - 1);
  localparam logic [SEG_W-1:0] LAST_FCS = SEG_W'(FCS_BYTES - 1);
  localparam logic [CNT_W-1:0] BODY_MIN = CNT_W'(MIN_BODY);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_BODY,
    ST_PAD,
    ST_FCS
  } state_t;

  state_t           state, stNext;
  logic [2:0]       bitCnt;
  logic [SEG_W-1:0] segCnt;
  logic [CNT_W-1:0] bodyCnt;
  logic             holdFull;
  logic             lastSeen;
  logic             fcsOff;
  logic             active;
  logic             byteEnd;
  logic             accept;
  logic             padNeeded;

  assign byteEnd   = (bitCnt == 3'd7);
  assign padNeeded = (bodyCnt < BODY_MIN);
  assign inReady   = (state == ST_IDLE) ||
                     ((state == ST_BODY) && !holdFull && !lastSeen && !byteEnd);
  assign accept    = inValid && inReady;
  assign frameOn   = active;

  always_comb begin
    dp         = '0;
    dp.src     = SRC_PRE;
    stNext     = state;
    dp.capture = accept;
    dp.shift   = active && !byteEnd;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          dp.load    = 1'b1;
          dp.src     = SRC_PRE;
          dp.crcInit = 1'b1;
          stNext     = ST_PRE;
        end
      end
      ST_PRE: begin
        if (byteEnd) begin
          dp.load = 1'b1;
          if (segCnt == LAST_PRE) begin
            dp.src = SRC_SFD;
            stNext = ST_SFD;
          end else begin
            dp.src = SRC_PRE;
          end
        end
      end
      ST_SFD: begin
        if (byteEnd) begin
          dp.load    = 1'b1;
          dp.src     = SRC_HOLD;
          dp.crcFeed = 1'b1;
          stNext     = ST_BODY;
        end
      end
      ST_BODY, ST_PAD: begin
        if (byteEnd) begin
          if (state == ST_BODY && holdFull) begin
            dp.load    = 1'b1;
            dp.src     = SRC_HOLD;
            dp.crcFeed = 1'b1;
          end else if (padNeeded) begin
            dp.load    = 1'b1;
            dp.src     = SRC_ZERO;
            dp.crcFeed = 1'b1;
            stNext     = ST_PAD;
          end else if (!fcsOff) begin
            dp.load     = 1'b1;
            dp.src      = SRC_FCS;
            dp.crcDrain = 1'b1;
            stNext      = ST_FCS;
          end else begin
            stNext = ST_IDLE;
          end
        end
      end
      ST_FCS: begin
        if (byteEnd) begin
          if (segCnt == LAST_FCS) begin
            stNext = ST_IDLE;
          end else begin
            dp.load     = 1'b1;
            dp.src      = SRC_FCS;
            dp.crcDrain = 1'b1;
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      active <= 1'b0;
      bitCnt <= 3'd0;
      segCnt <= '0;
    end else begin
      state  <= stNext;
      active <= (stNext != ST_IDLE);
      if (dp.load)     bitCnt <= 3'd0;
      else if (active) bitCnt <= bitCnt + 3'd1;
      if (stNext != state) segCnt <= '0;
      else if (dp.load)    segCnt <= segCnt + SEG_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bodyCnt <= '0;
    end else if (dp.crcInit) begin
      bodyCnt <= '0;
    end else if (dp.crcFeed && (bodyCnt != BODY_MIN)) begin
      bodyCnt <= bodyCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      lastSeen <= 1'b0;
      fcsOff   <= 1'b0;
    end else begin
      if (accept)                                   holdFull <= 1'b1;
      else if (dp.load && (dp.src == SRC_HOLD))     holdFull <= 1'b0;
      if (accept)                                   lastSeen <= inLast;
      if (accept && (state == ST_IDLE))             fcsOff   <= fcsDisable;
    end
  end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int HDR_BYTES = 14,
  parameter int MIN_DATA  = 46,
  parameter int FCS_BYTES = 4,
  parameter int BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fcsDisable,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              txBit,
  output logic              txActive
);

  dpCtrl_t dpStrobe;
  logic    serBit;
  logic    frameOn;

  eth_tx_control #(
    .PRE_BYTES (PRE_BYTES),
    .HDR_BYTES (HDR_BYTES),
    .MIN_DATA  (MIN_DATA),
    .FCS_BYTES (FCS_BYTES)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .fcsDisable (fcsDisable),
    .inValid    (inValid),
    .inLast     (inLast),
    .inReady    (inReady),
    .frameOn    (frameOn),
    .dp         (dpStrobe)
  );

  eth_tx_datapath #(
    .BYTE_W (BYTE_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (dpStrobe),
    .inData (inData),
    .serBit (serBit)
  );

  assign txBit    = frameOn & serBit;
  assign txActive = frameOn;

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk #(
  parameter int PRE_BYTES = 7,
  parameter int HDR_BYTES = 14,
  parameter int MIN_DATA  = 46
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inLast,
  input logic inReady,
  input logic txBit,
  input logic txActive
);

  localparam int MIN_BITS = (PRE_BYTES + 1 + HDR_BYTES + MIN_DATA) * 8;

  logic [15:0] runBits;
  logic        lastTaken;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         runBits <= '0;
    else if (txActive) runBits <= runBits + 16'd1;
    else               runBits <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                lastTaken <= 1'b0;
    else if (inValid && inReady && inLast)    lastTaken <= 1'b1;
    else if (!txActive)                       lastTaken <= 1'b0;
  end

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |-> inReady); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |-> !txBit); // R1

  AST_FIRST_BIT_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> txBit); // R2

  AST_NO_TAKE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (lastTaken && txActive) |-> !inReady); // R7

  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txActive) |-> ((runBits >= 16'(MIN_BITS)) && (runBits[2:0] == 3'd0))); // R8

  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (!txActive && inValid) |=> txActive); // R8

endmodule

bind eth_tx_framer eth_tx_framer_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inLast   (inLast),
  .inReady  (inReady),
  .txBit    (txBit),
  .txActive (txActive)
);

// File: tb/tb_eth_tx_framer.sv
`timescale 1ns/1ps
module tb_eth_tx_framer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fcsDisable = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inLast = 1'b0;
  logic       inReady;
  logic       txBit;
  logic       txActive;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  eth_tx_framer dut (
    .clk(clk), .rstN(rstN), .fcsDisable(fcsDisable), .inValid(inValid),
    .inData(inData), .inLast(inLast), .inReady(inReady),
    .txBit(txBit), .txActive(txActive)
  );

  // scoreboard state
  bit          expBits[$];
  int          expLen[$];
  string       expTag[$];
  bit          rxBits[$];
  logic [31:0] crcSer;
  bit          wasActive = 1'b0;
  int          idleNoise = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // serial CRC-32, bits taken bit 0 first of each byte
  function automatic void pushByte(input logic [7:0] b, input bit inCrc);
    for (int i = 0; i < 8; i++) begin
      expBits.push_back(b[i]);
      if (inCrc) begin
        bit fb;
        fb = crcSer[31] ^ b[i];
        crcSer = {crcSer[30:0], 1'b0};
        if (fb) crcSer = crcSer ^ 32'h04C11DB7;
      end
    end
  endfunction

  task automatic sendFrame(input int nData, input bit noFcs, input int seed, input string tag);
    logic [7:0] pl[$];
    int total;
    logic [31:0] fcs;
    for (int i = 0; i < 12; i++) pl.push_back(8'((seed * 37 + i * 11 + 3) & 255));
    pl.push_back(8'((nData >> 8) & 255));
    pl.push_back(8'(nData & 255));
    for (int i = 0; i < nData; i++) pl.push_back(8'((seed + i * 7 + (i >> 3)) & 255));
    // expected frame
    crcSer = 32'hFFFFFFFF;
    for (int i = 0; i < 7; i++) pushByte(8'h55, 1'b0);
    pushByte(8'hD5, 1'b0);
    foreach (pl[i]) pushByte(pl[i], 1'b1);
    total = pl.size();
    while (total < 60) begin
      pushByte(8'h00, 1'b1);
      total++;
    end
    if (!noFcs) begin
      fcs = ~crcSer;
      for (int i = 31; i >= 0; i--) expBits.push_back(fcs[i]);
      total += 4;
    end
    expLen.push_back((total + 8) * 8);
    expTag.push_back(tag);
    // drive bytes (called at a negedge)
    fcsDisable = noFcs;
    foreach (pl[i]) begin
      inData  = pl[i];
      inLast  = (i == pl.size() - 1);
      inValid = 1'b1;
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    // keep offering junk after the last byte: it must be refused
    begin
      int rdyHigh;
      rdyHigh = 0;
      inData  = 8'hA5;
      inLast  = 1'b1;
      inValid = 1'b1;
      fcsDisable = ~noFcs; // must not affect the frame in flight (R6)
      while (txActive) begin
        if (inReady) rdyHigh++;
        @(negedge clk);
      end
      check(rdyHigh == 0, "R7", "inReady high cycles after last byte", rdyHigh, 0);
    end
  endtask

  // monitor: collect bits, compare at the end of each frame
  always @(negedge clk) begin
    if (rstN) begin
      if (txActive) rxBits.push_back(txBit);
      else if (txBit) idleNoise++;
      if (wasActive && !txActive) begin
        int len;
        string tag;
        int badPre, badBody;
        int firstBad;
        len = (expLen.size() > 0) ? expLen.pop_front() : 0;
        tag = (expTag.size() > 0) ? expTag.pop_front() : "R3";
        check(rxBits.size() == len, "R8", "frame bit count", rxBits.size(), len);
        check((rxBits.size() % 8) == 0, "R8", "frame bits multiple of 8", rxBits.size() % 8, 0);
        badPre = 0; badBody = 0; firstBad = -1;
        for (int i = 0; i < len; i++) begin
          bit e, a;
          e = (expBits.size() > 0) ? expBits.pop_front() : 1'b0;
          a = (i < rxBits.size()) ? rxBits[i] : ~e;
          if (a != e) begin
            if (i < 64) badPre++; else badBody++;
            if (firstBad < 0) firstBad = i;
          end
        end
        check(badPre == 0, "R2", "preamble/delimiter bit mismatches", badPre, 0);
        check(badBody == 0, tag, "body bit mismatches (first bad bit index in next line)",
              badBody, 0);
        if (badBody != 0) $display("  first mismatching bit index %0d", firstBad);
        rxBits.delete();
      end
      wasActive = txActive;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txActive == 1'b0, "R1", "txActive in reset", txActive, 0);
    check(txBit == 1'b0, "R1", "txBit in reset", txBit, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);
    check(txActive == 1'b0, "R1", "txActive idle after reset", txActive, 0);

    sendFrame(1,   1'b0, 1, "R4 pad 45 bytes");
    sendFrame(46,  1'b0, 2, "R9 exact 60 bytes");
    sendFrame(45,  1'b0, 3, "R4 pad 1 byte");
    sendFrame(100, 1'b0, 4, "R5 long frame check sequence");
    sendFrame(6,   1'b1, 5, "R6 padded frame without check sequence");
    sendFrame(50,  1'b1, 6, "R6 unpadded frame without check sequence");
    sendFrame(20,  1'b0, 7, "R3 byte order after disabled frame");

    inValid = 1'b0;
    inLast  = 1'b0;
    repeat (4) @(negedge clk);
    check(expLen.size() == 0, "R8", "frames left unsent", expLen.size(), 0);
    check(idleNoise == 0, "R1", "txBit high while idle", idleNoise, 0);
    check(inReady == 1'b1, "R1", "inReady when idle at end", inReady, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule